// File: doc/BRIEF.md
# Wiper-Position Register Controller with I2C Slave Interface

This block is the serial front end of a 128-step digital potentiometer. It is an I2C slave with a fixed 7-bit device identifier, and it holds one volatile 7-bit wiper-position register. The register value is driven on an output port, which steers the resistor array outside this block. A fast system clock samples the bus lines SCL and SDA through two-flop synchronizers. The block finds START and STOP conditions and the SCL edges on the sampled copies. It drives SDA only through an open-drain enable: when the enable is high, the line is pulled low.

A write transfer is START, then identifier with R/W=0, then register address 00h, then one data byte, then STOP. A read transfer sets the address the same way, then sends a repeated START, then the identifier with R/W=1. The slave then returns the register byte again and again for as long as the master acknowledges each byte. For a short window after reset the slave ignores START conditions, so bus activity during power-up cannot disturb the register.

The controller has nine states:
- `ST_IDLE`: the slave waits for START.
- `ST_ID`, `ST_ADDR`, `ST_DATA`: the slave shifts in the identifier, the address or the data byte.
- `ST_ID_ACK`, `ST_ADDR_ACK`, `ST_DATA_ACK`: the slave pulls SDA low for the ninth clock.
- `ST_SEND`: the slave shifts the register byte out.
- `ST_MACK`: the slave samples the master's acknowledge.

The transitions are:
- START (outside the startup window) goes from any state to `ST_ID`.
- STOP goes from any state to `ST_IDLE`.
- `ST_ID` goes to `ST_ID_ACK` on an identifier match, or to `ST_IDLE` if the identifier does not match.
- `ST_ID_ACK` goes to `ST_ADDR` for a write, or to `ST_SEND` for a read.
- `ST_ADDR` goes to `ST_ADDR_ACK` if the address is 00h, or to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, and the register loads at this step.
- `ST_DATA_ACK` goes to `ST_IDLE`.
- `ST_SEND` goes to `ST_MACK`.
- `ST_MACK` goes back to `ST_SEND` on ACK, or to `ST_IDLE` on NACK.

Each transition other than START and STOP takes place on a falling SCL edge.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: After reset, `wiper_o` is 40h (mid-scale, decimal 64) and `sda_oe` is 0.
- R2: The slave reacts only after a START, which is SDA falling while SCL is high. Bytes clocked without a START get no ACK. STOP (SDA rising while SCL is high) returns the slave to idle. In idle the slave never drives SDA.
- R3: The identifier is the upper 7 bits of the first byte, received MSB first, and must equal 0111110. Bit 0 is R/W, with 1 meaning read. A byte with any other identifier gets no ACK, and the slave ignores all bytes that follow until the next START.
- R4: In a write (first byte 7Ch, address 00h, one data byte), the slave ACKs all three bytes by holding SDA low through the ninth SCL high phase. Bits 6:0 of the data byte become the new `wiper_o`, and bit 7 is discarded.
- R5: `wiper_o` takes the new value on the falling SCL edge that ends the data byte's LSB. This is before the ACK clock and before STOP. At all other times `wiper_o` is stable.
- R6: An address byte other than 00h gets no ACK. The data byte that follows gets no ACK and does not change `wiper_o`.
- R7: In a read (7Ch, 00h, repeated START, 7Dh), the slave ACKs all three bytes. It then sends {0, `wiper_o`} MSB first, with bit 7 always 0.
- R8: While the master ACKs in the ninth clock of a read byte, the slave sends the same byte again. After a master NACK the slave releases SDA and waits for START or STOP.
- R9: A START that arrives within `STARTUP_CYC` system clocks after reset is released is ignored. The transfer that follows gets no ACK and does not change `wiper_o`.
- R10: `sda_oe` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must be much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable; when high, SDA is pulled low |
| wiper_o | output | 7 | Current wiper position |

## Verification
Two functions can fall on the same falling SCL edge. In a write, the edge that closes the data LSB both loads the wiper register and starts the ACK drive. In a read, the same falling edge that ends an acknowledge clock releases or keeps SDA and also reloads the byte to be sent. The bench provokes the first case with writes whose data byte has bit 7 set. It judges the result by reading `wiper_o` during the ACK clock, before STOP is issued. It provokes the second case with a three-byte read in which the master ACKs twice and then NACKs. It checks that every byte matches the register and that SDA is free straight after the NACK.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SEND,
        ST_MACK
    } bus_state_t;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
    parameter int STARTUP_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic ready
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);

    // per-line pipes: index 1 = SCL, index 0 = SDA
    logic [1:0] meta_q, sync_q, prev_q;
    logic [CW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_q <= '0;
        else if (wait_q != LIMIT)
            wait_q <= wait_q + 1'b1;
    end

    always_comb begin
        scl_s     = sync_q[1];
        sda_s     = sync_q[0];
        ready     = (wait_q == LIMIT);
        scl_rise  = sync_q[1] & ~prev_q[1];
        scl_fall  = ~sync_q[1] & prev_q[1];
        start_det = ready & sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
        stop_det  = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
    end
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
    parameter int                 W         = 7,
    parameter logic [W-1:0]       RESET_VAL = 7'h40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RESET_VAL;
        else if (wr_en)
            q <= wr_data;
    end
endmodule

// File: rtl/slave_fsm.sv
module slave_fsm
    import wpot_pkg::*;
#(
    parameter logic [6:0] DEV_ID  = 7'b0111110,
    parameter int         WIPER_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic [WIPER_W-1:0] wiper_q,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [WIPER_W-1:0] wr_data,
    output bus_state_t         state_o
);
    localparam logic [CNT_W-1:0] RX_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

    bus_state_t        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              m_ack;
    logic              byte_done;

    assign byte_done = scl_fall && (bitcnt == RX_LAST);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ID;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ID:       if (byte_done)
                                 nxt = (shreg[BYTE_W-1:1] == DEV_ID) ? ST_ID_ACK : ST_IDLE;
                ST_ID_ACK:   if (scl_fall)
                                 nxt = shreg[0] ? ST_SEND : ST_ADDR;
                ST_ADDR:     if (byte_done)
                                 nxt = (shreg == '0) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_IDLE;
                ST_SEND:     if (scl_fall && bitcnt == TX_LAST) nxt = ST_MACK;
                ST_MACK:     if (scl_fall) nxt = m_ack ? ST_SEND : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            m_ack  <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det || nxt != state) begin
                bitcnt <= '0;
                if (nxt == ST_SEND)
                    shreg <= BYTE_W'(wiper_q);
            end else begin
                unique case (state)
                    ST_ID, ST_ADDR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise)
                            m_ack <= ~sda_s;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg[WIPER_W-1:0];
        unique case (state)
            ST_ID_ACK, ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_SEND:  sda_oe = ~shreg[BYTE_W-1];
            ST_DATA:  wr_en  = byte_done && !stop_det && !start_det;
            default:  ;
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
    import wpot_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'b0111110,
    parameter int         WIPER_W     = 7,
    parameter logic [WIPER_W-1:0] RESET_CODE = 7'h40,
    parameter int         STARTUP_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [WIPER_W-1:0] wiper_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, ready;
    logic wr_en;
    logic [WIPER_W-1:0] wr_data;
    bus_state_t state;

    bus_sampler #(.STARTUP_CYC(STARTUP_CYC)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .ready(ready)
    );

    slave_fsm #(.DEV_ID(DEV_ID), .WIPER_W(WIPER_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .wiper_q(wiper_o), .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data),
        .state_o(state)
    );

    wiper_store #(.W(WIPER_W), .RESET_VAL(RESET_CODE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(wiper_o)
    );
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk
    import wpot_pkg::*;
#(
    parameter int W = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         scl_fall,
    input logic         ready,
    input logic         sda_oe,
    input logic [W-1:0] wiper_o,
    input bus_state_t   state
);
    AST_RESET_MIDSCALE: assert property (@(posedge clk)
        !rst_n |=> (wiper_o == W'(7'h40) && !sda_oe)); // R1

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R2

    AST_WIPER_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o != $past(wiper_o)) |-> $past(scl_fall)); // R5

    AST_STARTUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (state == ST_IDLE)); // R9

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
endmodule

bind wiper_i2c_ctrl wiper_ctrl_chk #(.W(WIPER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .ready(ready), .sda_oe(sda_oe), .wiper_o(wiper_o), .state(state)
);

// File: tb/sim_wiper_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_wiper_i2c_ctrl;
    localparam int Q = 8;             // system clocks per quarter SCL period
    localparam logic [7:0] ID_W = 8'h7C;
    localparam logic [7:0] ID_R = 8'h7D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [6:0] wiper_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;             // 250 MHz

    assign sda_line = sda_m & ~sda_oe;

    wiper_i2c_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wiper_o(wiper_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();       // also a repeated START from SCL low
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
        ack = ~sda_line;
        qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl_m = 1'b1; qw();
            b[i] = sda_line;
            qw(); scl_m = 1'b0; qw();
        end
        sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic write_xfer(input logic [7:0] id, input logic [7:0] addr, input logic [7:0] data,
                              output logic a0, output logic a1, output logic a2);
        bus_start();
        send_byte(id, a0);
        send_byte(addr, a1);
        send_byte(data, a2);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 wiper after reset", wiper_o, 7'h40);
        chk("R1 sda_oe after reset", sda_oe, 1'b0);
    endtask

    task automatic t_startup();
        logic a0, a1, a2;
        write_xfer(ID_W, 8'h00, 8'h22, a0, a1, a2);
        chk("R9 id ack in startup window", a0, 1'b0);
        chk("R9 data ack in startup window", a2, 1'b0);
        chk("R9 wiper unchanged", wiper_o, 7'h40);
        bus_stop();
    endtask

    task automatic t_no_start();
        logic a;
        scl_m = 1'b0; qw();
        send_byte(ID_W, a);
        chk("R2 no ack without START", a, 1'b0);
        bus_stop();
        chk("R2 idle after stop", sda_oe, 1'b0);
    endtask

    task automatic t_write(input logic [7:0] data, input logic [6:0] exp, input string tag);
        logic a0, a1, a2;
        write_xfer(ID_W, 8'h00, data, a0, a1, a2);
        chk({"R4 id ack ", tag}, a0, 1'b1);
        chk({"R4 addr ack ", tag}, a1, 1'b1);
        chk({"R4 data ack ", tag}, a2, 1'b1);
        chk({"R5 wiper before STOP ", tag}, wiper_o, exp);
        bus_stop();
        chk({"R10 released after stop ", tag}, sda_oe, 1'b0);
    endtask

    task automatic t_bad_addr();
        logic a0, a1, a2;
        write_xfer(ID_W, 8'h01, 8'h33, a0, a1, a2);
        chk("R6 id ack", a0, 1'b1);
        chk("R6 bad addr nack", a1, 1'b0);
        chk("R6 data nack", a2, 1'b0);
        chk("R6 wiper unchanged", wiper_o, 7'h7F);
        bus_stop();
    endtask

    task automatic t_bad_id();
        logic a0, a1, a2;
        write_xfer(8'h3C, 8'h00, 8'h11, a0, a1, a2);
        chk("R3 wrong id nack", a0, 1'b0);
        chk("R3 following byte ignored", a1, 1'b0);
        chk("R3 data ignored", a2, 1'b0);
        chk("R3 wiper unchanged", wiper_o, 7'h7F);
        bus_stop();
    endtask

    task automatic t_read(input int n, input logic [7:0] exp);
        logic a0, a1, a2;
        logic [7:0] b;
        bus_start();
        send_byte(ID_W, a0);
        send_byte(8'h00, a1);
        bus_start();
        send_byte(ID_R, a2);
        chk("R7 id(w) ack", a0, 1'b1);
        chk("R7 addr ack", a1, 1'b1);
        chk("R7 id(r) ack", a2, 1'b1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk((k == 0) ? "R7 read byte" : "R8 repeated byte", b, exp);
        end
        chk("R8 released after master nack", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_startup();
        repeat (100) @(negedge clk);
        t_no_start();
        t_write(8'h15, 7'h15, "15h");
        t_write(8'hFF, 7'h7F, "FFh bit7 dropped");
        t_bad_addr();
        t_bad_id();
        t_read(3, 8'h7F);
        t_write(8'hAA, 7'h2A, "AAh");
        t_read(1, 8'h2A);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule